// File: doc/BRIEF.md
# DRAM Controller Init-Status Register Stub

This block takes the place of a DRAM controller's register window so that boot firmware can run its start-up polling loops to the end without any real memory hardware behind them. It holds three 32-bit registers: a control word, a calibration control word and a calibration status word. It also models the completion effects that firmware waits for. Command bits written to the control word read back as already cleared. A write to the calibration control word raises the calibration-done flag in the status word.

The bus is a plain synchronous word port. Each cycle it takes at most one address, with a write strobe and a read strobe that may both be high. It never applies back-pressure: every access is accepted in the cycle it is presented. Read data comes back one cycle later, qualified by a valid flag. Offsets that hold no register, offsets at or above the end of the implemented range, and misaligned addresses all read as zero and ignore writes. Any access to one of these raises a one-cycle error pulse.

Top module: `dram_init_stub`

## Requirements
- R1: After reset, the control word (offset 0x000) reads 0x80020000, the calibration control word (offset 0x0A8) reads 0x07B00000 and the calibration status word (offset 0x0B0) reads 0x80000000.
- R2: A read issued in cycle k drives `rd_valid` high with its data in cycle k+1. When `rd_valid` is low, `rd_data` is zero.
- R3: A write to the control word stores the written value with bit 31 (init request) and bit 30 (training request) forced to 0. All other bits are stored as written.
- R4: A write to the calibration control word stores the value exactly as written.
- R5: A write to the calibration control word sets bit 31 (calibration done) of the status word and leaves the status word's other bits unchanged.
- R6: A write to the calibration status word stores the value as written, including bit 31.
- R7: An aligned offset below 0x2E4 that holds no register reads zero, and a write there changes none of the three registers.
- R8: Offsets from 0x2E4 to the top of the window read zero, and writes there change none of the three registers.
- R9: An address whose two low bits are not zero is treated as holding no register: it reads zero and a write there changes nothing.
- R10: `err` is high for exactly the cycle after a read or write to an address covered by R7, R8 or R9. It stays low after accesses to the three registers.
- R11: When a read and a write to the same register occur in the same cycle, the read returns the value from before the write, and the write takes effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | ADDR_W (12) | Byte address of the access |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 32 | Read data, valid with `rd_valid` |
| rd_valid | output | 1 | Read data valid, one cycle after `rd_en` |
| err | output | 1 | One-cycle pulse for an access to an unimplemented, out-of-range or misaligned address |

## Verification
A wrong stored value is invisible until that register is read, and it then appears at `rd_data` one cycle after the read strobe. For this reason every write in the sequence is followed by a read of the register it targets and of the neighbouring register it could disturb. A done flag that fails to be set, or a command bit that fails to clear, shows on the first status or control read after the triggering write. A decode fault shows two ways: a bad access writes into a real register, which the following reads expose, and `err` at the cycle after the access is wrong. A read port that samples the register after the write, instead of before it, shows only when a read and a write to the same register share a cycle, so the bench issues that case directly.

// File: rtl/dram_stub_pkg.sv
`timescale 1ns/1ps
package dram_stub_pkg;
  typedef enum logic [2:0] {
    HIT_CTRL,
    HIT_CALC,
    HIT_CALS,
    MISS_HOLE,
    MISS_RANGE,
    MISS_ALIGN
  } slot_e;

  localparam int NREG     = 3;
  localparam int IDX_CTRL = 0;
  localparam int IDX_CALC = 1;
  localparam int IDX_CALS = 2;

  function automatic logic is_miss(slot_e s);
    return (s == MISS_HOLE) || (s == MISS_RANGE) || (s == MISS_ALIGN);
  endfunction
endpackage

// File: rtl/dram_stub_decode.sv
`timescale 1ns/1ps
module dram_stub_decode
  import dram_stub_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int CTRL_OFS  = 'h000,
  parameter int CALC_OFS  = 'h0A8,
  parameter int CALS_OFS  = 'h0B0,
  parameter int RANGE_END = 'h2E4
) (
  input  logic [ADDR_W-1:0] addr,
  output slot_e             slot
);
  always_comb begin
    if (addr[1:0] != 2'b00)                  slot = MISS_ALIGN;
    else if (addr >= ADDR_W'(RANGE_END))     slot = MISS_RANGE;
    else if (addr == ADDR_W'(CTRL_OFS))      slot = HIT_CTRL;
    else if (addr == ADDR_W'(CALC_OFS))      slot = HIT_CALC;
    else if (addr == ADDR_W'(CALS_OFS))      slot = HIT_CALS;
    else                                     slot = MISS_HOLE;
  end
endmodule

// File: rtl/dram_stub_regs.sv
`timescale 1ns/1ps
module dram_stub_regs
  import dram_stub_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter logic [DATA_W-1:0] CTRL_RST  = 32'h8002_0000,
  parameter logic [DATA_W-1:0] CALC_RST  = 32'h07B0_0000,
  parameter logic [DATA_W-1:0] CALS_RST  = 32'h8000_0000,
  parameter logic [DATA_W-1:0] CMD_MASK  = 32'hC000_0000,
  parameter logic [DATA_W-1:0] DONE_MASK = 32'h8000_0000
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  slot_e                        slot,
  input  logic [DATA_W-1:0]            wr_data,
  output logic [NREG-1:0][DATA_W-1:0]  regs_q
);
  localparam logic [NREG-1:0][DATA_W-1:0] RST_VAL = {CALS_RST, CALC_RST, CTRL_RST};

  logic [NREG-1:0][DATA_W-1:0] regs_d;
  logic wr_ctrl, wr_calc, wr_cals;

  assign wr_ctrl = wr_en && (slot == HIT_CTRL);
  assign wr_calc = wr_en && (slot == HIT_CALC);
  assign wr_cals = wr_en && (slot == HIT_CALS);

  always_comb begin
    regs_d = regs_q;
    // command requests read back as already finished
    if (wr_ctrl) regs_d[IDX_CTRL] = wr_data & ~CMD_MASK;
    if (wr_calc) regs_d[IDX_CALC] = wr_data;
    // a direct status write lands first, the done flag is merged after it
    if (wr_cals) regs_d[IDX_CALS] = wr_data;
    if (wr_calc) regs_d[IDX_CALS] = regs_d[IDX_CALS] | DONE_MASK;
  end

  for (genvar g = 0; g < NREG; g++) begin : g_word
    always_ff @(posedge clk) begin
      if (!rst_n) regs_q[g] <= RST_VAL[g];
      else        regs_q[g] <= regs_d[g];
    end
  end
endmodule

// File: rtl/dram_stub_rdport.sv
`timescale 1ns/1ps
module dram_stub_rdport
  import dram_stub_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         rd_en,
  input  logic                         wr_en,
  input  slot_e                        slot,
  input  logic [NREG-1:0][DATA_W-1:0]  regs_q,
  output logic [DATA_W-1:0]            rd_data,
  output logic                         rd_valid,
  output logic                         err
);
  logic [DATA_W-1:0] sel;

  always_comb begin
    case (slot)
      HIT_CTRL: sel = regs_q[IDX_CTRL];
      HIT_CALC: sel = regs_q[IDX_CALC];
      HIT_CALS: sel = regs_q[IDX_CALS];
      default:  sel = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
      err      <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      rd_data  <= rd_en ? sel : '0;
      err      <= (rd_en || wr_en) && is_miss(slot);
    end
  end
endmodule

// File: rtl/dram_init_stub.sv
`timescale 1ns/1ps
module dram_init_stub
  import dram_stub_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int DATA_W    = 32,
  parameter int CTRL_OFS  = 'h000,
  parameter int CALC_OFS  = 'h0A8,
  parameter int CALS_OFS  = 'h0B0,
  parameter int RANGE_END = 'h2E4,
  parameter int INIT_BIT  = 31,
  parameter int TRAIN_BIT = 30,
  parameter int DONE_BIT  = 31,
  parameter logic [DATA_W-1:0] CTRL_RST = 32'h8002_0000,
  parameter logic [DATA_W-1:0] CALC_RST = 32'h07B0_0000,
  parameter logic [DATA_W-1:0] CALS_RST = 32'h8000_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              err
);
  localparam logic [DATA_W-1:0] CMD_MASK =
    (DATA_W'(1) << INIT_BIT) | (DATA_W'(1) << TRAIN_BIT);
  localparam logic [DATA_W-1:0] DONE_MASK = DATA_W'(1) << DONE_BIT;

  slot_e                        slot;
  logic [NREG-1:0][DATA_W-1:0]  regs_q;

  dram_stub_decode #(
    .ADDR_W(ADDR_W), .CTRL_OFS(CTRL_OFS), .CALC_OFS(CALC_OFS),
    .CALS_OFS(CALS_OFS), .RANGE_END(RANGE_END)
  ) u_decode (
    .addr(addr),
    .slot(slot)
  );

  dram_stub_regs #(
    .DATA_W(DATA_W), .CTRL_RST(CTRL_RST), .CALC_RST(CALC_RST),
    .CALS_RST(CALS_RST), .CMD_MASK(CMD_MASK), .DONE_MASK(DONE_MASK)
  ) u_regs (
    .clk(clk),
    .rst_n(rst_n),
    .wr_en(wr_en),
    .slot(slot),
    .wr_data(wr_data),
    .regs_q(regs_q)
  );

  dram_stub_rdport #(
    .DATA_W(DATA_W)
  ) u_rdport (
    .clk(clk),
    .rst_n(rst_n),
    .rd_en(rd_en),
    .wr_en(wr_en),
    .slot(slot),
    .regs_q(regs_q),
    .rd_data(rd_data),
    .rd_valid(rd_valid),
    .err(err)
  );
endmodule

// File: rtl/dram_init_stub_chk.sv
`timescale 1ns/1ps
module dram_init_stub_chk #(
  parameter int ADDR_W    = 12,
  parameter int DATA_W    = 32,
  parameter int CTRL_OFS  = 'h000,
  parameter int CALC_OFS  = 'h0A8,
  parameter int CALS_OFS  = 'h0B0,
  parameter int RANGE_END = 'h2E4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr,
  input logic              wr_en,
  input logic              rd_en,
  input logic [DATA_W-1:0] rd_data,
  input logic              rd_valid,
  input logic              err
);
  logic at_ctrl, at_calc, at_cals, at_reg;
  logic ctrl_wr_q, calc_wr_q;

  assign at_ctrl = addr == ADDR_W'(CTRL_OFS);
  assign at_calc = addr == ADDR_W'(CALC_OFS);
  assign at_cals = addr == ADDR_W'(CALS_OFS);
  assign at_reg  = at_ctrl || at_calc || at_cals;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_wr_q <= 1'b0;
      calc_wr_q <= 1'b0;
    end else begin
      ctrl_wr_q <= wr_en && at_ctrl;
      calc_wr_q <= wr_en && at_calc;
    end
  end

  // R2
  rd_valid_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);
  // R2
  rd_valid_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rd_valid);
  // R2
  idle_data_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |-> rd_data == '0);
  // R3
  cmd_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr_q && rd_en && !wr_en && at_ctrl) |=> rd_data[DATA_W-1 -: 2] == 2'b00);
  // R5
  cal_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (calc_wr_q && rd_en && !wr_en && at_cals) |=> rd_data[DATA_W-1]);
  // R8
  range_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr >= ADDR_W'(RANGE_END)) |=> (rd_data == '0) && err);
  // R10
  err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> $past(rd_en || wr_en));
  // R10
  err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((rd_en || wr_en) && at_reg) |=> !err);
endmodule

bind dram_init_stub dram_init_stub_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTRL_OFS(CTRL_OFS),
  .CALC_OFS(CALC_OFS), .CALS_OFS(CALS_OFS), .RANGE_END(RANGE_END)
) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
  .rd_data(rd_data), .rd_valid(rd_valid), .err(err)
);

// File: tb/dram_init_stub_test.sv
`timescale 1ns/1ps
module dram_init_stub_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] addr = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [31:0] rd_data;
  logic        rd_valid;
  logic        err;

  always #2.5 clk = ~clk;

  dram_init_stub uut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .rd_valid(rd_valid), .err(err)
  );

  typedef struct {
    logic [31:0] d;
    logic        e;
    string       tag;
  } exp_t;

  exp_t q[$];
  int pass_n = 0;
  int fail_n = 0;

  // reference model built from the requirements
  logic [31:0] m_ctrl = 32'h8002_0000;
  logic [31:0] m_calc = 32'h07B0_0000;
  logic [31:0] m_cals = 32'h8000_0000;

  function automatic logic hit(input logic [11:0] a);
    return (a == 12'h000) || (a == 12'h0A8) || (a == 12'h0B0);
  endfunction

  function automatic logic [31:0] mread(input logic [11:0] a);
    if (a == 12'h000) return m_ctrl;
    if (a == 12'h0A8) return m_calc;
    if (a == 12'h0B0) return m_cals;
    return 32'h0;
  endfunction

  task automatic mwrite(input logic [11:0] a, input logic [31:0] d);
    if (a == 12'h000) m_ctrl = d & 32'h3FFF_FFFF;
    if (a == 12'h0B0) m_cals = d;
    if (a == 12'h0A8) begin
      m_calc = d;
      m_cals = m_cals | 32'h8000_0000;
    end
  endtask

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    if (ok) pass_n++;
    else begin
      fail_n++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", pass_n, pass_n + fail_n);
  endtask

  task automatic rd(input logic [11:0] a, input string tag);
    exp_t x;
    @(negedge clk);
    addr = a; rd_en = 1'b1; wr_en = 1'b0;
    x.d = mread(a); x.e = !hit(a); x.tag = tag;
    q.push_back(x);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d, input string tag);
    @(negedge clk);
    addr = a; wr_data = d; wr_en = 1'b1; rd_en = 1'b0;
    mwrite(a, d);
    @(negedge clk);
    wr_en = 1'b0;
    check(err == !hit(a), {tag, " err after write"}, {31'b0, err}, {31'b0, !hit(a)});
  endtask

  task automatic rw(input logic [11:0] a, input logic [31:0] d, input string tag);
    exp_t x;
    @(negedge clk);
    addr = a; wr_data = d; wr_en = 1'b1; rd_en = 1'b1;
    x.d = mread(a); x.e = !hit(a); x.tag = tag;
    q.push_back(x);
    mwrite(a, d);
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
  endtask

  // monitor: pops one expected item per returned read
  always @(negedge clk) begin
    exp_t x;
    if (rst_n && rd_valid) begin
      if (q.size() == 0) begin
        check(1'b0, "R2 unexpected rd_valid", rd_data, 32'h0);
      end else begin
        x = q.pop_front();
        check(rd_data == x.d, {x.tag, " data"}, rd_data, x.d);
        check(err == x.e, {x.tag, " err (R10)"}, {31'b0, err}, {31'b0, x.e});
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    check(1'b0, "watchdog expired", 32'h0, 32'h0);
    summary();
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    check(rd_valid == 1'b0, "R2 reset rd_valid", {31'b0, rd_valid}, 32'h0);
    check(rd_data == 32'h0, "R2 reset rd_data", rd_data, 32'h0);
    check(err == 1'b0, "R10 reset err", {31'b0, err}, 32'h0);
    rst_n = 1'b1;

    // R1 reset values
    rd(12'h000, "R1 ctrl reset");
    rd(12'h0A8, "R1 calc reset");
    rd(12'h0B0, "R1 cals reset");

    // R3 command bits self-clear
    wr(12'h000, 32'hC000_0001, "R3 both cmds");
    rd(12'h000, "R3 both cmds readback");
    wr(12'h000, 32'h4000_1234, "R3 train only");
    rd(12'h000, "R3 train readback");
    wr(12'h000, 32'h8ABC_0000, "R3 init only");
    rd(12'h000, "R3 init readback");
    wr(12'h000, 32'h3FFF_FFFF, "R3 no cmd");
    rd(12'h000, "R3 other bits kept");

    // R6 status write, then R4/R5
    wr(12'h0B0, 32'h0000_0005, "R6 status write");
    rd(12'h0B0, "R6 status readback");
    wr(12'h0A8, 32'h1234_5678, "R4 calc write");
    rd(12'h0A8, "R4 calc readback");
    rd(12'h0B0, "R5 done set");
    wr(12'h0B0, 32'h0000_0007, "R6 clear done");
    rd(12'h0B0, "R6 done cleared");
    wr(12'h0A8, 32'h0000_0000, "R5 calc zero write");
    rd(12'h0B0, "R5 done set others kept");
    rd(12'h0A8, "R4 calc zero readback");

    // R7 holes
    rd(12'h004, "R7 hole 004");
    rd(12'h0AC, "R7 hole 0AC");
    rd(12'h2E0, "R7 hole 2E0");
    wr(12'h004, 32'hDEAD_BEEF, "R7 hole write");
    wr(12'h0B4, 32'h0000_0000, "R7 hole write near status");
    rd(12'h000, "R7 ctrl untouched");
    rd(12'h0B0, "R7 cals untouched");

    // R8 out of range
    rd(12'h2E4, "R8 range start");
    rd(12'hFFC, "R8 range top");
    wr(12'h2E4, 32'hFFFF_FFFF, "R8 range write");
    wr(12'hFFC, 32'h0000_0000, "R8 range top write");
    rd(12'h0A8, "R8 calc untouched");
    rd(12'h0B0, "R8 cals untouched");

    // R9 misaligned
    rd(12'h001, "R9 misaligned read");
    rd(12'h0AA, "R9 misaligned near calc");
    wr(12'h002, 32'hFFFF_FFFF, "R9 misaligned ctrl write");
    wr(12'h0B3, 32'h0000_0000, "R9 misaligned cals write");
    wr(12'h0A9, 32'hAAAA_5555, "R9 misaligned calc write");
    rd(12'h000, "R9 ctrl untouched");
    rd(12'h0B0, "R9 cals untouched");
    rd(12'h0A8, "R9 calc untouched");

    // R11 read and write in one cycle
    rw(12'h0A8, 32'h0F0F_0F0F, "R11 calc old value");
    rd(12'h0A8, "R11 calc new value");
    rw(12'h000, 32'hFFFF_0000, "R11 ctrl old value");
    rd(12'h000, "R11 ctrl new value");

    // R2 back-to-back reads, mixed hits and misses
    for (int i = 0; i < 6; i++) begin
      exp_t x;
      logic [11:0] a;
      a = (i % 3 == 0) ? 12'h000 : (i % 3 == 1) ? 12'h0B0 : 12'h300;
      @(negedge clk);
      addr = a; rd_en = 1'b1; wr_en = 1'b0;
      x.d = mread(a); x.e = !hit(a); x.tag = "R2 burst read";
      q.push_back(x);
    end
    @(negedge clk);
    rd_en = 1'b0;

    repeat (4) @(negedge clk);
    check(q.size() == 0, "R2 all reads returned", q.size(), 32'h0);
    summary();
    $finish;
  end
endmodule